// File: doc/BRIEF.md
# Two-Way Sectored Cache Directory

This block holds the tag directory and makes the hit/miss decision for a unified, write-through, two-way set-associative cache on a 32-bit byte-addressed bus. Each of the two banks keeps one entry per set. An entry has a tag, a tag-valid flag and one valid flag per doubleword, so a single tag covers an eight-doubleword sector. One replacement bit per set, shared by both banks, names the bank that the next sector refill will take.

A request gives an operation and an address in the same cycle. The block compares the addressed set's tags in both banks in parallel. In that cycle it reports hit or fill, the bank to use and the doubleword index for the data array. The directory update takes effect at the next rising clock edge. The data array, the bus arbitration and the memory timing sit outside the block. Besides reads and writes, the directory accepts a snoop, which removes one doubleword, and a flush, which empties the whole cache.

Top module: `cache_dir_2way`

## Requirements
- R1: The address splits into a tag (bits 31..14), a set index (bits 13..5, 512 sets) and a doubleword select (bits 4..2). `o_dw_idx` always equals address bits 13..2, with the set index in its upper nine bits.
- R2: A read or write hits when one bank holds a valid, equal tag in the addressed set and that bank's valid flag for the addressed doubleword is set. Both banks are compared in the same cycle. On a hit `o_hit`=1, `o_fill`=0, and `o_bank` names the hitting bank (0 = bank A, 1 = bank B).
- R3: After a read hit, the set's replacement bit points to the bank that did not hit.
- R4: On a read where neither bank has a valid matching tag, `o_fill`=1, `o_newtag`=1 and `o_bank` equals the set's replacement bit. That bank takes the new tag and becomes tag-valid, and the replacement bit then points to the other bank. A valid tag is never present in both banks of one set.
- R5: A sector refill (R4) leaves only the addressed doubleword valid in the refilled entry. The other seven doublewords then miss.
- R6: On a read whose tag is valid and matching in one bank while the addressed doubleword flag is clear, `o_fill`=1, `o_newtag`=0 and `o_bank` is that bank, whatever the replacement bit holds. Only that one flag is set, and the replacement bit then points to the other bank.
- R7: A write hit reports as in R2 and changes neither the tags, the valid flags nor the replacement bit. A write miss reports `o_hit`=0, `o_fill`=0, `o_bank`=0 and changes nothing.
- R8: A snoop clears the addressed doubleword flag in the bank whose valid tag matches. The other doublewords are left alone, and a snoop whose tag matches no bank changes nothing. A snoop reports all-zero `o_hit`/`o_fill`/`o_newtag`/`o_bank`.
- R9: A flush invalidates every tag in both banks and sets every replacement bit to bank A. It reports all-zero outputs.
- R10: After reset the directory is in the flushed state of R9. While `req_valid` is 0, `o_hit`, `o_fill`, `o_newtag` and `o_bank` are 0 and the directory keeps its contents.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock, rising edge |
| rst | input | 1 | Synchronous active-high reset |
| req_valid | input | 1 | A request is present this cycle |
| req_op | input | 2 | Operation: 0 read, 1 write, 2 snoop, 3 flush |
| req_addr | input | 32 | Byte address of the request |
| o_hit | output | 1 | Read or write hit |
| o_fill | output | 1 | Read miss: the addressed doubleword is to be loaded |
| o_newtag | output | 1 | The fill replaces the whole sector (tag miss) |
| o_bank | output | 1 | Bank for the hit or the fill (0 = A, 1 = B) |
| o_dw_idx | output | 12 | Doubleword index within a bank |

## Verification
The directed sequence goes after the decisions that depend on history. A hit must move the replacement bit; a design that skips this refills the wrong bank on the next tag miss. A refill must clear the stale doubleword flags; otherwise a read of a new sector returns a false hit on data the previous tag left behind. A partial miss must stay in its own bank instead of following the replacement bit, or a tag ends up in both banks. The sequence also checks that write hits leave the replacement bit untouched, that a snoop removes only one doubleword, and that a flush resets the replacement bits as well as the tags. The random phase uses a small pool of tags and sets, including set 511, so that evictions, partial misses and snoops on live entries come up often.

// File: rtl/cdir_pkg.sv
package cdir_pkg;

    typedef enum logic [1:0] {
        OP_READ  = 2'd0,
        OP_WRITE = 2'd1,
        OP_SNOOP = 2'd2,
        OP_FLUSH = 2'd3
    } dir_op_e;

    // per-bank directory update for the addressed set
    typedef struct packed {
        logic load_tag;   // write tag, set tag-valid, keep only addressed dw
        logic set_line;   // set addressed dw flag
        logic clr_line;   // clear addressed dw flag
    } bank_cmd_t;

    typedef struct packed {
        logic hit;
        logic fill;
        logic newtag;
        logic bank;
    } dir_resp_t;

    function automatic logic other_bank(input logic b);
        return ~b;
    endfunction

endpackage

// File: rtl/cdir_bank.sv
module cdir_bank
    import cdir_pkg::*;
#(
    parameter int TAG_W  = 18,
    parameter int SET_W  = 9,
    parameter int LINE_W = 3
) (
    input  logic              clk,
    input  logic              rst,
    input  logic              flush,
    input  logic [SET_W-1:0]  set_idx,
    input  logic [LINE_W-1:0] line_idx,
    input  logic [TAG_W-1:0]  tag,
    input  bank_cmd_t         cmd,
    output logic              tag_hit,
    output logic              line_ok
);
    localparam int SETS  = 1 << SET_W;
    localparam int LINES = 1 << LINE_W;

    logic [TAG_W-1:0] tag_q [SETS];
    logic [LINES-1:0] lv_q  [SETS];
    logic [SETS-1:0]  tv_q;

    always_ff @(posedge clk) begin
        if (rst || flush) begin
            tv_q <= '0;
        end else if (cmd.load_tag) begin
            tv_q[set_idx] <= 1'b1;
        end
    end

    always_ff @(posedge clk) begin
        if (cmd.load_tag) begin
            tag_q[set_idx] <= tag;
            lv_q[set_idx]  <= LINES'(1) << line_idx;
        end else if (cmd.set_line) begin
            lv_q[set_idx][line_idx] <= 1'b1;
        end else if (cmd.clr_line) begin
            lv_q[set_idx][line_idx] <= 1'b0;
        end
    end

    assign tag_hit = tv_q[set_idx] && (tag_q[set_idx] == tag);
    assign line_ok = lv_q[set_idx][line_idx];

endmodule

// File: rtl/cdir_lru.sv
module cdir_lru #(
    parameter int SET_W = 9
) (
    input  logic                  clk,
    input  logic                  rst,
    input  logic                  flush,
    input  logic [SET_W-1:0]      set_idx,
    input  logic                  wr_en,
    input  logic                  wr_val,
    output logic                  rd_val,
    output logic [(1<<SET_W)-1:0] lru_vec
);
    localparam int SETS = 1 << SET_W;

    logic [SETS-1:0] lru_q;

    always_ff @(posedge clk) begin
        if (rst || flush) begin
            lru_q <= '0;
        end else if (wr_en) begin
            lru_q[set_idx] <= wr_val;
        end
    end

    assign rd_val  = lru_q[set_idx];
    assign lru_vec = lru_q;

endmodule

// File: rtl/cdir_ctrl.sv
module cdir_ctrl
    import cdir_pkg::*;
(
    input  logic                  valid,
    input  dir_op_e               op,
    input  logic [1:0]            match,
    input  logic [1:0]            line_ok,
    input  logic                  lru_bit,
    output dir_resp_t             resp,
    output bank_cmd_t [1:0]       cmd,
    output logic                  lru_we,
    output logic                  lru_val,
    output logic                  flush
);
    logic hit_any;

    assign hit_any = |(match & line_ok);

    always_comb begin
        resp    = '0;
        cmd     = '0;
        lru_we  = 1'b0;
        lru_val = 1'b0;
        flush   = 1'b0;
        if (valid) begin
            case (op)
                OP_READ: begin
                    if (hit_any) begin
                        resp.hit  = 1'b1;
                        resp.bank = match[1];
                    end else if (|match) begin
                        resp.fill = 1'b1;
                        resp.bank = match[1];
                        cmd[match[1]].set_line = 1'b1;
                    end else begin
                        resp.fill   = 1'b1;
                        resp.newtag = 1'b1;
                        resp.bank   = lru_bit;
                        cmd[lru_bit].load_tag = 1'b1;
                    end
                    lru_we  = 1'b1;
                    lru_val = other_bank(resp.bank);
                end
                OP_WRITE: begin
                    if (hit_any) begin
                        resp.hit  = 1'b1;
                        resp.bank = match[1];
                    end
                end
                OP_SNOOP: begin
                    for (int b = 0; b < 2; b++) begin
                        cmd[b].clr_line = match[b];
                    end
                end
                default: begin
                    flush = 1'b1;
                end
            endcase
        end
    end

endmodule

// File: rtl/cache_dir_2way.sv
module cache_dir_2way
    import cdir_pkg::*;
#(
    parameter int ADDR_W = 32,
    parameter int SET_W  = 9,
    parameter int LINE_W = 3
) (
    input  logic                    clk,
    input  logic                    rst,
    input  logic                    req_valid,
    input  logic [1:0]              req_op,
    input  logic [ADDR_W-1:0]       req_addr,
    output logic                    o_hit,
    output logic                    o_fill,
    output logic                    o_newtag,
    output logic                    o_bank,
    output logic [SET_W+LINE_W-1:0] o_dw_idx
);
    localparam int BYTE_W = 2;
    localparam int TAG_W  = ADDR_W - SET_W - LINE_W - BYTE_W;
    localparam int SETS   = 1 << SET_W;
    localparam int NBANK  = 2;

    logic [TAG_W-1:0]  tag;
    logic [SET_W-1:0]  set_idx;
    logic [LINE_W-1:0] line_idx;
    logic [BYTE_W-1:0] unused_byte;

    assign tag         = req_addr[ADDR_W-1 -: TAG_W];
    assign set_idx     = req_addr[BYTE_W+LINE_W +: SET_W];
    assign line_idx    = req_addr[BYTE_W +: LINE_W];
    assign unused_byte = req_addr[BYTE_W-1:0];

    bank_cmd_t [NBANK-1:0] bank_cmd;
    logic [NBANK-1:0]      bank_match;
    logic [NBANK-1:0]      bank_line;
    logic                  lru_bit, lru_we, lru_val, flush;
    logic [SETS-1:0]       lru_vec;
    dir_resp_t             resp;

    generate
        for (genvar b = 0; b < NBANK; b++) begin : g_bank
            cdir_bank #(
                .TAG_W (TAG_W),
                .SET_W (SET_W),
                .LINE_W(LINE_W)
            ) u_bank (
                .clk     (clk),
                .rst     (rst),
                .flush   (flush),
                .set_idx (set_idx),
                .line_idx(line_idx),
                .tag     (tag),
                .cmd     (bank_cmd[b]),
                .tag_hit (bank_match[b]),
                .line_ok (bank_line[b])
            );
        end
    endgenerate

    cdir_lru #(.SET_W(SET_W)) u_lru (
        .clk    (clk),
        .rst    (rst),
        .flush  (flush),
        .set_idx(set_idx),
        .wr_en  (lru_we),
        .wr_val (lru_val),
        .rd_val (lru_bit),
        .lru_vec(lru_vec)
    );

    cdir_ctrl u_ctrl (
        .valid  (req_valid),
        .op     (dir_op_e'(req_op)),
        .match  (bank_match),
        .line_ok(bank_line),
        .lru_bit(lru_bit),
        .resp   (resp),
        .cmd    (bank_cmd),
        .lru_we (lru_we),
        .lru_val(lru_val),
        .flush  (flush)
    );

    assign o_hit    = resp.hit;
    assign o_fill   = resp.fill;
    assign o_newtag = resp.newtag;
    assign o_bank   = resp.bank;
    assign o_dw_idx = {set_idx, line_idx};

endmodule

// File: rtl/cdir_chk.sv
module cdir_chk #(
    parameter int SET_W = 9
) (
    input logic                  clk,
    input logic                  rst,
    input logic                  req_valid,
    input logic [1:0]            req_op,
    input logic                  o_hit,
    input logic                  o_fill,
    input logic                  o_newtag,
    input logic                  o_bank,
    input logic [1:0]            bank_match,
    input logic [SET_W-1:0]      set_idx,
    input logic [(1<<SET_W)-1:0] lru_vec
);
    // R2
    hit_fill_excl_chk: assert property (@(posedge clk) disable iff (rst)
        !(o_hit && o_fill));

    // R4
    newtag_needs_fill_chk: assert property (@(posedge clk) disable iff (rst)
        o_newtag |-> o_fill);

    // R4
    tag_unique_chk: assert property (@(posedge clk) disable iff (rst)
        $countones(bank_match) <= 1);

    // R10
    idle_quiet_chk: assert property (@(posedge clk) disable iff (rst)
        !req_valid |-> (!o_hit && !o_fill && !o_newtag && !o_bank));

    // R3
    lru_after_hit_chk: assert property (@(posedge clk) disable iff (rst)
        (req_valid && req_op == 2'd0 && o_hit) |=> (lru_vec[$past(set_idx)] != $past(o_bank)));

    // R7
    write_keeps_lru_chk: assert property (@(posedge clk) disable iff (rst)
        (req_valid && req_op == 2'd1) |=> $stable(lru_vec));

    // R9
    flush_lru_chk: assert property (@(posedge clk) disable iff (rst)
        (req_valid && req_op == 2'd3) |=> (lru_vec == '0));
endmodule

bind cache_dir_2way cdir_chk #(.SET_W(SET_W)) u_chk (
    .clk       (clk),
    .rst       (rst),
    .req_valid (req_valid),
    .req_op    (req_op),
    .o_hit     (o_hit),
    .o_fill    (o_fill),
    .o_newtag  (o_newtag),
    .o_bank    (o_bank),
    .bank_match(bank_match),
    .set_idx   (set_idx),
    .lru_vec   (lru_vec)
);

// File: tb/cache_dir_2way_test.sv
`timescale 1ns/1ps
module cache_dir_2way_test;
    import cdir_pkg::*;

    logic        clk = 1'b0;
    logic        rst = 1'b1;
    logic        req_valid = 1'b0;
    logic [1:0]  req_op = 2'd0;
    logic [31:0] req_addr = '0;
    logic        o_hit, o_fill, o_newtag, o_bank;
    logic [11:0] o_dw_idx;

    int total = 0;
    int bad   = 0;
    bit done  = 0;

    always #2.5 clk = ~clk;

    cache_dir_2way uut (
        .clk      (clk),
        .rst      (rst),
        .req_valid(req_valid),
        .req_op   (req_op),
        .req_addr (req_addr),
        .o_hit    (o_hit),
        .o_fill   (o_fill),
        .o_newtag (o_newtag),
        .o_bank   (o_bank),
        .o_dw_idx (o_dw_idx)
    );

    // reference directory built from the requirements
    logic [17:0] m_tag [2][512];
    bit          m_tv  [2][512];
    bit [7:0]    m_lv  [2][512];
    bit          m_lru [512];

    function automatic logic [31:0] mk(input int t, input int s, input int l);
        return {18'(t), 9'(s), 3'(l), 2'b00};
    endfunction

    task automatic m_flush();
        for (int b = 0; b < 2; b++)
            for (int s = 0; s < 512; s++) m_tv[b][s] = 0;
        for (int s = 0; s < 512; s++) m_lru[s] = 0;
    endtask

    // returns {hit, fill, newtag, bank} and applies the update
    task automatic m_step(input dir_op_e op, input logic [31:0] a, output logic [3:0] e);
        logic [17:0] t = a[31:14];
        int s = int'(a[13:5]);
        int l = int'(a[4:2]);
        bit mt [2];
        bit hb;
        e = 4'b0;
        for (int b = 0; b < 2; b++) mt[b] = m_tv[b][s] && (m_tag[b][s] == t);
        case (op)
            OP_READ: begin
                if ((mt[0] && m_lv[0][s][l]) || (mt[1] && m_lv[1][s][l])) begin
                    hb = mt[1];
                    e = {1'b1, 1'b0, 1'b0, hb};
                end else if (mt[0] || mt[1]) begin
                    hb = mt[1];
                    e = {1'b0, 1'b1, 1'b0, hb};
                    m_lv[hb][s][l] = 1;
                end else begin
                    hb = m_lru[s];
                    e = {1'b0, 1'b1, 1'b1, hb};
                    m_tag[hb][s] = t;
                    m_tv[hb][s]  = 1;
                    m_lv[hb][s]  = 8'(1) << l;
                end
                m_lru[s] = ~hb;
            end
            OP_WRITE: begin
                if ((mt[0] && m_lv[0][s][l]) || (mt[1] && m_lv[1][s][l]))
                    e = {1'b1, 1'b0, 1'b0, mt[1]};
            end
            OP_SNOOP: begin
                for (int b = 0; b < 2; b++) if (mt[b]) m_lv[b][s][l] = 0;
            end
            default: m_flush();
        endcase
    endtask

    task automatic check(input logic [3:0] exp, input logic [11:0] eidx, input string rq);
        logic [3:0] got = {o_hit, o_fill, o_newtag, o_bank};
        total++;
        if (got !== exp || o_dw_idx !== eidx) begin
            bad++;
            $display("FAIL %s: hit/fill/newtag/bank=%b idx=%h expected %b idx=%h",
                     rq, got, o_dw_idx, exp, eidx);
        end
    endtask

    task automatic run(input dir_op_e op, input logic [31:0] a, input logic [3:0] exp, input string rq);
        @(negedge clk);
        req_valid = 1'b1;
        req_op    = op;
        req_addr  = a;
        #1;
        check(exp, a[13:2], rq);
        @(posedge clk);
    endtask

    initial begin
        #(200000 * 5);
        if (!done) begin
            total++;
            bad++;
            $display("FAIL watchdog: actual=timeout expected=completion");
            $display("test done: total=%0d bad=%0d", total, bad);
            $finish;
        end
    end

    initial begin
        logic [3:0] e;
        void'($urandom(32'd7741));
        repeat (3) @(posedge clk);
        @(negedge clk);
        rst = 1'b0;
        req_addr = mk(5, 3, 2);
        #1;
        check(4'b0000, 12'(3*8+2), "R10 idle outputs");

        // directed sequence on set 3, tags 1..4 and 9
        run(OP_READ,  mk(1,3,0), 4'b0110, "R10 reset LRU picks bank A (R4)");
        run(OP_READ,  mk(1,3,0), 4'b1000, "R2 hit bank A");
        run(OP_READ,  mk(2,3,0), 4'b0111, "R4 tag miss fills bank B");
        run(OP_READ,  mk(2,3,5), 4'b0101, "R6 line miss same bank");
        run(OP_READ,  mk(2,3,5), 4'b1001, "R6 filled line now hits");
        run(OP_READ,  mk(1,3,0), 4'b1000, "R2 hit bank A again");
        run(OP_READ,  mk(3,3,0), 4'b0111, "R3 victim is bank not hit");
        run(OP_READ,  mk(3,3,5), 4'b0101, "R5 stale line bits cleared");
        run(OP_WRITE, mk(1,3,0), 4'b1000, "R7 write hit");
        run(OP_WRITE, mk(9,3,0), 4'b0000, "R7 write miss");
        run(OP_READ,  mk(4,3,0), 4'b0110, "R7 write hit kept LRU");
        run(OP_SNOOP, mk(9,3,5), 4'b0000, "R8 snoop no match");
        run(OP_SNOOP, mk(3,3,0), 4'b0000, "R8 snoop match");
        run(OP_READ,  mk(3,3,5), 4'b1001, "R8 other line kept");
        run(OP_READ,  mk(3,3,0), 4'b0101, "R8 snooped line misses");
        run(OP_READ,  mk(4,3,0), 4'b1000, "R2 hit A sets LRU to B");
        run(OP_READ,  mk(7,511,7), 4'b0110, "R1 top set fill");
        run(OP_READ,  mk(7,511,7), 4'b1000, "R1 top set hit");
        run(OP_FLUSH, mk(0,0,0), 4'b0000, "R9 flush");
        run(OP_READ,  mk(3,3,5), 4'b0110, "R9 flushed, LRU back to A");
        run(OP_READ,  mk(7,511,7), 4'b0110, "R9 other set flushed");

        // random phase from a flushed state
        run(OP_FLUSH, mk(0,0,0), 4'b0000, "R9 flush before random");
        m_flush();
        for (int i = 0; i < 3000; i++) begin
            int r = $urandom_range(0, 99);
            int sp = $urandom_range(0, 3);
            int s = (sp == 0) ? 0 : (sp == 1) ? 3 : (sp == 2) ? 7 : 511;
            logic [31:0] a = mk(16'h100 + $urandom_range(0, 4), s, $urandom_range(0, 7));
            dir_op_e op;
            string rq;
            if (r < 60)      begin op = OP_READ;  rq = "R2 R4 R6 random read"; end
            else if (r < 78) begin op = OP_WRITE; rq = "R7 random write"; end
            else if (r < 98) begin op = OP_SNOOP; rq = "R8 random snoop"; end
            else             begin op = OP_FLUSH; rq = "R9 random flush"; end
            m_step(op, a, e);
            run(op, a, e, rq);
        end

        @(negedge clk);
        req_valid = 1'b0;
        done = 1;
        $display("test done: total=%0d bad=%0d", total, bad);
        $finish;
    end

endmodule